// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Controller

This block is the control unit of a five-stage, in-order, single-issue pipeline: fetch, decode, execute, memory and write-back. It sees only the control metadata of the instruction sitting in decode: its source and destination register numbers, a valid bit, a register-write flag and a load flag. It also takes a strobe that says the instruction now in the memory stage is a branch that resolved taken or mispredicted. From these inputs it keeps its own shadow copy of the execute, memory and write-back pipeline registers. It then decides whether the decode instruction may advance, and which source feeds each ALU operand once that instruction reaches execute.

A mode input picks between two policies. With bypassing on, results travel from the later pipeline registers straight back to the ALU inputs. Only a load that is directly followed by a consumer of its result costs a bubble. With bypassing off, a consumer waits in decode until its producer is in write-back, because the register file writes before it reads in that cycle. A taken branch squashes the three younger instructions in fetch, decode and execute, and that squash overrides any stall.

Top module: `hazard_fwd_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, stall_o, flush_o, ex_valid_o, mem_valid_o and wb_we_o are 0, and both operand selects are 0.
- R2: The operand select codes are 0 for the register file, 1 for the result held in the execute/memory register and 2 for the result held in the memory/write-back register. With bypassing on, an ALU producer followed directly by its consumer causes no stall, and the consumer enters execute with select 1. With one instruction between them the select is 2, and with two between them it is 0.
- R3: With bypassing on, a load followed directly by a consumer of its destination stalls decode for exactly one cycle, and the consumer then enters execute with select 2. With one instruction between them there is no stall and the select is 2.
- R4: With bypassing off, a consumer whose producer (ALU or load) is 1, 2 or 3 instructions ahead stalls for 2, 1 or 0 cycles respectively, and always enters execute with select 0.
- R5: When two instructions in flight write the same register, the operand comes from the younger one.
- R6: Register 0 never creates a dependence, and a write to register 0 never raises wb_we_o.
- R7: While stall_o is 1, the instruction in decode does not advance and a bubble enters execute, so ex_valid_o is 0 on the next cycle.
- R8: When br_taken_i is 1 and the memory stage holds a valid instruction, flush_o is 1. On the next cycle ex_valid_o and mem_valid_o are 0, and the squashed instructions never write back. br_taken_i has no effect while the memory stage is empty.
- R9: A flush in the same cycle as a hazard wins: stall_o stays 0.
- R10: Bubbles never write: over any instruction sequence, wb_we_o pulses exactly once for each valid, non-squashed instruction that has its write flag set and a non-zero destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_en_i | input | 1 | 1 enables operand bypassing, 0 forces waits until write-back |
| id_valid_i | input | 1 | Decode stage holds a real instruction |
| id_rs1_i | input | AW | First source register of the decode instruction |
| id_rs2_i | input | AW | Second source register of the decode instruction |
| id_rd_i | input | AW | Destination register of the decode instruction |
| id_wen_i | input | 1 | Decode instruction writes a register |
| id_load_i | input | 1 | Decode instruction is a load |
| br_taken_i | input | 1 | Memory-stage branch resolved taken or mispredicted |
| stall_o | output | 1 | Hold PC and the fetch/decode register, insert bubble into execute |
| flush_o | output | 1 | Squash the instructions in fetch, decode and execute |
| fwd_a_o | output | 2 | Operand A source select for the instruction in execute |
| fwd_b_o | output | 2 | Operand B source select for the instruction in execute |
| ex_valid_o | output | 1 | Execute stage holds a real instruction |
| mem_valid_o | output | 1 | Memory stage holds a real instruction |
| wb_we_o | output | 1 | Register-file write enable in write-back |
| wb_rd_o | output | AW | Register-file write address in write-back |

## Verification
The bench sweeps producer kind, producer-to-consumer distance, operand slot and bypass mode. For each case it compares the stall count and the operand select against values worked out arithmetically. A design that forwarded loads without a bubble, counted the no-bypass penalty from the wrong stage, or picked the older of two writers would show a wrong stall count or select code. Separate cases put a dependence on register 0 and place a taken branch on top of a pending load-use stall. There, a controller that lets the stall win, or that lets a squashed instruction or a bubble reach write-back, shows up as a wrong stall value or a wrong write-back count.

// File: rtl/hfc_pkg.sv
package hfc_pkg;
  typedef enum logic [1:0] {
    SRC_RF    = 2'd0,
    SRC_EXMEM = 2'd1,
    SRC_MEMWB = 2'd2
  } fwd_src_e;
endpackage

// File: rtl/hfc_match.sv
module hfc_match #(
  parameter int AW = 5
) (
  input  logic          stg_valid,
  input  logic          stg_wen,
  input  logic [AW-1:0] stg_rd,
  input  logic [AW-1:0] src,
  output logic          hit
);
  // Register 0 is constant zero, so it can never carry a dependence.
  assign hit = stg_valid && stg_wen && (stg_rd != '0) && (stg_rd == src);
endmodule

// File: rtl/hfc_track.sv
module hfc_track #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take_id,
  input  logic          flush,
  input  logic          id_valid,
  input  logic          id_wen,
  input  logic          id_load,
  input  logic [AW-1:0] id_rd,
  output logic          ex_v,
  output logic          ex_w,
  output logic          ex_l,
  output logic [AW-1:0] ex_rd,
  output logic          mem_v,
  output logic          mem_w,
  output logic [AW-1:0] mem_rd,
  output logic          wb_we,
  output logic [AW-1:0] wb_rd
);
  logic load_id;
  logic keep_ex;

  assign load_id = take_id && id_valid;
  assign keep_ex = !flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_v   <= 1'b0;
      ex_w   <= 1'b0;
      ex_l   <= 1'b0;
      ex_rd  <= '0;
      mem_v  <= 1'b0;
      mem_w  <= 1'b0;
      mem_rd <= '0;
      wb_we  <= 1'b0;
      wb_rd  <= '0;
    end else begin
      ex_v   <= load_id;
      ex_w   <= load_id && id_wen;
      ex_l   <= load_id && id_load;
      ex_rd  <= load_id ? id_rd : '0;
      mem_v  <= keep_ex && ex_v;
      mem_w  <= keep_ex && ex_v && ex_w;
      mem_rd <= keep_ex ? ex_rd : '0;
      wb_we  <= mem_v && mem_w && (mem_rd != '0);
      wb_rd  <= mem_rd;
    end
  end
endmodule

// File: rtl/hfc_fwd_sel.sv
module hfc_fwd_sel #(
  parameter int NSRC = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load_en,
  input  logic                  fwd_en,
  input  logic [NSRC-1:0]       hit_ex,
  input  logic [NSRC-1:0]       hit_mem,
  output logic [NSRC-1:0][1:0]  sel
);
  import hfc_pkg::*;

  // Selects are resolved in decode and registered, so the execute stage sees
  // them straight from a flop. The stage now in execute becomes the
  // execute/memory register next cycle and is the younger writer.
  for (genvar s = 0; s < NSRC; s++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst || !load_en || !fwd_en) begin
        sel[s] <= SRC_RF;
      end else if (hit_ex[s]) begin
        sel[s] <= SRC_EXMEM;
      end else if (hit_mem[s]) begin
        sel[s] <= SRC_MEMWB;
      end else begin
        sel[s] <= SRC_RF;
      end
    end
  end
endmodule

// File: rtl/hazard_fwd_ctrl.sv
module hazard_fwd_ctrl #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fwd_en_i,
  input  logic          id_valid_i,
  input  logic [AW-1:0] id_rs1_i,
  input  logic [AW-1:0] id_rs2_i,
  input  logic [AW-1:0] id_rd_i,
  input  logic          id_wen_i,
  input  logic          id_load_i,
  input  logic          br_taken_i,
  output logic          stall_o,
  output logic          flush_o,
  output logic [1:0]    fwd_a_o,
  output logic [1:0]    fwd_b_o,
  output logic          ex_valid_o,
  output logic          mem_valid_o,
  output logic          wb_we_o,
  output logic [AW-1:0] wb_rd_o
);
  logic [NSRC-1:0][AW-1:0] src;
  logic [NSRC-1:0]         hit_ex;
  logic [NSRC-1:0]         hit_mem;
  logic [NSRC-1:0][1:0]    sel;

  logic          ex_v, ex_w, ex_l;
  logic [AW-1:0] ex_rd;
  logic          mem_v, mem_w;
  logic [AW-1:0] mem_rd;
  logic          wb_we;
  logic [AW-1:0] wb_rd;

  logic load_use, raw_wait, hazard, flush, stall, take_id;

  always_comb begin
    src    = '0;
    src[0] = id_rs1_i;
    if (NSRC > 1) src[NSRC-1] = id_rs2_i;
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    hfc_match #(.AW(AW)) u_ex (
      .stg_valid (ex_v),
      .stg_wen   (ex_w),
      .stg_rd    (ex_rd),
      .src       (src[s]),
      .hit       (hit_ex[s])
    );
    hfc_match #(.AW(AW)) u_mem (
      .stg_valid (mem_v),
      .stg_wen   (mem_w),
      .stg_rd    (mem_rd),
      .src       (src[s]),
      .hit       (hit_mem[s])
    );
  end

  // With bypass, only a load still in execute is too late for its consumer.
  // Without bypass, anything not yet in write-back is too late.
  assign load_use = id_valid_i && ex_l && (|hit_ex);
  assign raw_wait = id_valid_i && ((|hit_ex) || (|hit_mem));
  assign hazard   = fwd_en_i ? load_use : raw_wait;
  assign flush    = br_taken_i && mem_v;
  assign stall    = hazard && !flush;
  assign take_id  = !flush && !stall;

  hfc_track #(.AW(AW)) u_track (
    .clk      (clk),
    .rst      (rst),
    .take_id  (take_id),
    .flush    (flush),
    .id_valid (id_valid_i),
    .id_wen   (id_wen_i),
    .id_load  (id_load_i),
    .id_rd    (id_rd_i),
    .ex_v     (ex_v),
    .ex_w     (ex_w),
    .ex_l     (ex_l),
    .ex_rd    (ex_rd),
    .mem_v    (mem_v),
    .mem_w    (mem_w),
    .mem_rd   (mem_rd),
    .wb_we    (wb_we),
    .wb_rd    (wb_rd)
  );

  hfc_fwd_sel #(.NSRC(NSRC)) u_sel (
    .clk     (clk),
    .rst     (rst),
    .load_en (take_id && id_valid_i),
    .fwd_en  (fwd_en_i),
    .hit_ex  (hit_ex),
    .hit_mem (hit_mem),
    .sel     (sel)
  );

  assign stall_o     = stall;
  assign flush_o     = flush;
  assign fwd_a_o     = sel[0];
  assign fwd_b_o     = sel[NSRC-1];
  assign ex_valid_o  = ex_v;
  assign mem_valid_o = mem_v;
  assign wb_we_o     = wb_we;
  assign wb_rd_o     = wb_rd;
endmodule

// File: rtl/hfc_checker.sv
module hfc_checker #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          fwd_en_i,
  input logic          br_taken_i,
  input logic          stall_o,
  input logic          flush_o,
  input logic [1:0]    fwd_a_o,
  input logic [1:0]    fwd_b_o,
  input logic          ex_valid_o,
  input logic          mem_valid_o,
  input logic          wb_we_o,
  input logic [AW-1:0] wb_rd_o
);
  AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    stall_o |=> !ex_valid_o); // R7

  AST_FLUSH_SQUASH: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> (!ex_valid_o && !mem_valid_o)); // R8

  AST_FLUSH_NEEDS_MEM: assert property (@(posedge clk) disable iff (rst)
    (br_taken_i && !mem_valid_o) |-> !flush_o); // R8

  AST_FLUSH_OVER_STALL: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> !stall_o); // R9

  AST_NO_R0_WRITE: assert property (@(posedge clk) disable iff (rst)
    wb_we_o |-> (wb_rd_o != '0)); // R6

  AST_NOFWD_SEL: assert property (@(posedge clk) disable iff (rst)
    !fwd_en_i |=> (fwd_a_o == 2'd0 && fwd_b_o == 2'd0)); // R4

  AST_BUBBLE_SEL: assert property (@(posedge clk) disable iff (rst)
    !ex_valid_o |-> (fwd_a_o == 2'd0 && fwd_b_o == 2'd0)); // R7

  AST_SEL_CODE: assert property (@(posedge clk) disable iff (rst)
    (fwd_a_o != 2'd3) && (fwd_b_o != 2'd3)); // R2
endmodule

bind hazard_fwd_ctrl hfc_checker #(.AW(AW)) u_hfc_checker (
  .clk         (clk),
  .rst         (rst),
  .fwd_en_i    (fwd_en_i),
  .br_taken_i  (br_taken_i),
  .stall_o     (stall_o),
  .flush_o     (flush_o),
  .fwd_a_o     (fwd_a_o),
  .fwd_b_o     (fwd_b_o),
  .ex_valid_o  (ex_valid_o),
  .mem_valid_o (mem_valid_o),
  .wb_we_o     (wb_we_o),
  .wb_rd_o     (wb_rd_o)
);

// File: tb/tb_hazard_fwd_ctrl.sv
module tb_hazard_fwd_ctrl;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fwd_en_i = 1'b1;
  logic          id_valid_i = 1'b0;
  logic [AW-1:0] id_rs1_i = '0;
  logic [AW-1:0] id_rs2_i = '0;
  logic [AW-1:0] id_rd_i = '0;
  logic          id_wen_i = 1'b0;
  logic          id_load_i = 1'b0;
  logic          br_taken_i = 1'b0;
  logic          stall_o, flush_o, ex_valid_o, mem_valid_o, wb_we_o;
  logic [1:0]    fwd_a_o, fwd_b_o;
  logic [AW-1:0] wb_rd_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hazard_fwd_ctrl #(.AW(AW)) dut (
    .clk(clk), .rst(rst), .fwd_en_i(fwd_en_i), .id_valid_i(id_valid_i),
    .id_rs1_i(id_rs1_i), .id_rs2_i(id_rs2_i), .id_rd_i(id_rd_i),
    .id_wen_i(id_wen_i), .id_load_i(id_load_i), .br_taken_i(br_taken_i),
    .stall_o(stall_o), .flush_o(flush_o), .fwd_a_o(fwd_a_o), .fwd_b_o(fwd_b_o),
    .ex_valid_o(ex_valid_o), .mem_valid_o(mem_valid_o),
    .wb_we_o(wb_we_o), .wb_rd_o(wb_rd_o)
  );

  // Program store
  int p_rs1[16], p_rs2[16], p_rd[16];
  bit p_w[16], p_l[16];
  int plen;

  // Results of one run
  int r_stalls, r_sel_a, r_sel_b, r_wb, r_bubble_bad;
  int r_flush, r_flush_stall, r_post_ex, r_post_mem;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(input int i, input int rs1, input int rs2, input int rd,
                     input bit w, input bit l);
    p_rs1[i] = rs1; p_rs2[i] = rs2; p_rd[i] = rd; p_w[i] = w; p_l[i] = l;
  endtask

  // Runs the program; cons is the index of the instruction whose selects are
  // captured, br_cyc the loop cycle at which br_taken_i is raised (-1: none).
  task automatic run(input int cons, input int br_cyc);
    int pc = 0;
    r_stalls = 0; r_sel_a = -1; r_sel_b = -1; r_wb = 0; r_bubble_bad = 0;
    r_flush = 0; r_flush_stall = 0; r_post_ex = -1; r_post_mem = -1;
    for (int cyc = 0; cyc < plen + 10; cyc++) begin
      bit st, fl, adv, entered;
      @(negedge clk);
      if (pc < plen) begin
        id_valid_i = 1'b1;
        id_rs1_i = AW'(p_rs1[pc]); id_rs2_i = AW'(p_rs2[pc]);
        id_rd_i = AW'(p_rd[pc]); id_wen_i = p_w[pc]; id_load_i = p_l[pc];
      end else begin
        id_valid_i = 1'b0; id_rs1_i = '0; id_rs2_i = '0; id_rd_i = '0;
        id_wen_i = 1'b0; id_load_i = 1'b0;
      end
      br_taken_i = (cyc == br_cyc);
      #1;
      st = stall_o; fl = flush_o;
      if (st) r_stalls++;
      if (fl) begin r_flush++; r_flush_stall = int'(st); end
      adv = (pc < plen) && !st && !fl;
      entered = adv && (pc == cons);
      @(posedge clk); #1;
      if (wb_we_o) r_wb++;
      if (st && ex_valid_o) r_bubble_bad++;
      if (fl) begin r_post_ex = int'(ex_valid_o); r_post_mem = int'(mem_valid_o); end
      if (entered) begin r_sel_a = int'(fwd_a_o); r_sel_b = int'(fwd_b_o); end
      if (fl) pc = plen;
      else if (adv) pc++;
    end
    br_taken_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 stall in reset", int'(stall_o), 0);
    chk("R1 ex_valid in reset", int'(ex_valid_o), 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 stall after reset", int'(stall_o), 0);
    chk("R1 flush after reset", int'(flush_o), 0);
    chk("R1 mem_valid after reset", int'(mem_valid_o), 0);
    chk("R1 wb_we after reset", int'(wb_we_o), 0);
    chk("R1 sel after reset", int'(fwd_a_o) + int'(fwd_b_o), 0);

    // Sweep: mode x producer kind x distance x operand slot
    for (int fe = 0; fe < 2; fe++) begin
      for (int ld = 0; ld < 2; ld++) begin
        for (int d = 1; d <= 3; d++) begin
          for (int slot = 0; slot < 2; slot++) begin
            int exp_st, exp_sel;
            string tg;
            fwd_en_i = fe[0];
            put(0, 0, 0, 5, 1'b1, ld[0]);
            for (int k = 1; k < d; k++) put(k, 0, 0, 10 + k, 1'b1, 1'b0);
            put(d, slot == 0 ? 5 : 0, slot == 1 ? 5 : 0, 9, 1'b1, 1'b0);
            plen = d + 1;
            run(d, -1);
            if (fe == 1) begin
              exp_st  = (ld == 1 && d == 1) ? 1 : 0;
              exp_sel = (d == 3) ? 0 : ((d == 1 && ld == 0) ? 1 : 2);
              tg = (ld == 1) ? "R3" : "R2";
            end else begin
              exp_st  = (d < 3) ? 3 - d : 0;
              exp_sel = 0;
              tg = "R4";
            end
            chk($sformatf("%s stalls fe=%0d ld=%0d d=%0d slot=%0d", tg, fe, ld, d, slot),
                r_stalls, exp_st);
            chk($sformatf("%s sel fe=%0d ld=%0d d=%0d slot=%0d", tg, fe, ld, d, slot),
                slot == 0 ? r_sel_a : r_sel_b, exp_sel);
            chk($sformatf("%s unused sel fe=%0d ld=%0d d=%0d", tg, fe, ld, d),
                slot == 0 ? r_sel_b : r_sel_a, 0);
            chk($sformatf("R10 wb count fe=%0d ld=%0d d=%0d", fe, ld, d), r_wb, d + 1);
            chk($sformatf("R7 bubble on stall fe=%0d ld=%0d d=%0d", fe, ld, d),
                r_bubble_bad, 0);
          end
        end
      end
    end

    // R5: two writers of r5, consumer right after the younger one
    fwd_en_i = 1'b1;
    put(0, 0, 0, 5, 1'b1, 1'b0);
    put(1, 0, 0, 5, 1'b1, 1'b0);
    put(2, 5, 5, 9, 1'b1, 1'b0);
    plen = 3;
    run(2, -1);
    chk("R5 youngest writer sel a", r_sel_a, 1);
    chk("R5 youngest writer sel b", r_sel_b, 1);
    chk("R5 no stall", r_stalls, 0);

    // R6: producer writes r0, consumer reads r0, in both modes
    for (int fe = 0; fe < 2; fe++) begin
      fwd_en_i = fe[0];
      put(0, 0, 0, 0, 1'b1, 1'b1);
      put(1, 0, 0, 9, 1'b1, 1'b0);
      plen = 2;
      run(1, -1);
      chk($sformatf("R6 r0 no stall fe=%0d", fe), r_stalls, 0);
      chk($sformatf("R6 r0 sel fe=%0d", fe), r_sel_a, 0);
      chk($sformatf("R6 r0 no write fe=%0d", fe), r_wb, 1);
    end

    // R8/R9: branch in MEM while a load-use stall is pending in decode
    fwd_en_i = 1'b1;
    put(0, 0, 0, 0, 1'b0, 1'b0);
    put(1, 0, 0, 5, 1'b1, 1'b1);
    put(2, 5, 0, 9, 1'b1, 1'b0);
    plen = 3;
    run(2, 2);
    chk("R8 flush raised", r_flush, 1);
    chk("R9 flush beats stall", r_flush_stall, 0);
    chk("R8 ex squashed", r_post_ex, 0);
    chk("R8 mem squashed", r_post_mem, 0);
    chk("R8 squashed never write", r_wb, 0);

    // Same program without branch: control for the write count
    run(2, -1);
    chk("R10 unsquashed write count", r_wb, 2);
    chk("R3 control stall count", r_stalls, 1);

    // R8: branch strobe with empty memory stage is ignored
    put(0, 0, 0, 7, 1'b1, 1'b0);
    plen = 1;
    run(0, 0);
    chk("R8 no flush when mem empty", r_flush, 0);
    chk("R8 write survives ignored strobe", r_wb, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule